// File: doc/BRIEF.md
# Command Block Header Validator

This block screens the header of a paired request/response command block before any command logic sees it. On a one-cycle start pulse it samples the requester's privilege bit, the request length, the response length and the command code. One cycle later it presents exactly one outcome for a single cycle. The outcome is a privileged-operation exception, an operand exception, a length-error response, or a dispatch.

A dispatch carries a command index for the four supported commands, or an invalid-command response code when the code is not recognised. For the listing command the block also checks that the response area can hold a whole number of fixed-size list entries after the list header. It then reports how many entries fit.

The checks run in a fixed priority order: privilege, request bounds, response bounds, joint size, exact request length, command code. Memory traffic and the execution of the commands are left to neighbouring logic.

Top module: `cmd_hdr_validator`

## Requirements
- R1: When `problem_state_i` is 1 at a start pulse, the outcome is the privileged-operation exception (outcome bit 0), regardless of every other input.
- R2: Otherwise, the outcome is the operand exception (outcome bit 1) when the request length is below 16, above 8184, or not a multiple of 8.
- R3: Otherwise, the outcome is the operand exception when the response length is below 8, above 8176, or not a multiple of 8.
- R4: Otherwise, the outcome is the operand exception when the request length plus the response length exceeds 8192 (the sum is taken without overflow).
- R5: Otherwise, a request length other than 32 gives the length-error outcome (outcome bit 2) with response code 0x0020.
- R6: Otherwise, the outcome is dispatch (outcome bit 3). Command code 0x0002 (list) gives index 0, 0x0005 (set) gives index 1, 0x0001 (query function) gives index 2 and 0x0003 (query group) gives index 3. For set and both queries the response code is 0x0010 (good).
- R7: A dispatched command code outside those four gives index 0, response code 0x0030 and entry count 0.
- R8: For the list command, a response length below 48 gives response code 0x0040, condition code 0 and entry count 0.
- R9: For the list command with a response length of at least 48, when the response length minus the 32-byte list header is not a multiple of the 32-byte entry size, the response code is 0x0020 and the condition code is 3.
- R10: For a list command whose response area fits, the response code is 0x0010, the condition code is 0, and the entry count is (response length − 32) / 32.
- R11: `out_valid_o` rises in the cycle after a start pulse and stays high for one cycle only. While it is high exactly one outcome bit is set. While it is low the outcome, index, response code, condition code and entry count are all zero.
- R12: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Sample the header inputs this cycle |
| problem_state_i | input | 1 | Requester runs unprivileged |
| req_len_i | input | 16 | Request block length in bytes |
| rsp_len_i | input | 16 | Response block length in bytes |
| cmd_code_i | input | 16 | Command code from the request header |
| out_valid_o | output | 1 | Outcome valid strobe, one cycle |
| outcome_o | output | 4 | One-hot: bit0 privilege, bit1 operand, bit2 length error, bit3 dispatch |
| cmd_idx_o | output | 2 | Index of the dispatched command |
| rsp_code_o | output | 16 | Response code written back to the block |
| cond_code_o | output | 2 | Condition code |
| list_entries_o | output | 16 | Number of list entries that fit |

## Verification
A corrupted bound, alignment test or priority order shows up on `outcome_o` in the cycle after the start pulse that crosses the faulty edge. That is why the lengths are swept in fine steps across each limit and along the joint-sum diagonal. A wrong header subtraction or divisor in the list sizing shows up as a wrong entry count or condition code on the first list vector above 48 bytes. A strobe that lingers or a stale outcome shows up one cycle later, when the outputs must have returned to zero.

// File: rtl/cbv_pkg.sv
package cbv_pkg;

  localparam int CBV_LEN_W  = 16;
  localparam int CBV_IDX_W  = 2;
  localparam int CBV_CC_W   = 2;
  localparam int CBV_OUT_W  = 4;

  localparam logic [CBV_OUT_W-1:0] OUT_NONE   = 4'b0000;
  localparam logic [CBV_OUT_W-1:0] OUT_PRIV   = 4'b0001;
  localparam logic [CBV_OUT_W-1:0] OUT_OPER   = 4'b0010;
  localparam logic [CBV_OUT_W-1:0] OUT_LENERR = 4'b0100;
  localparam logic [CBV_OUT_W-1:0] OUT_DISP   = 4'b1000;

  localparam logic [15:0] CMD_LIST  = 16'h0002;
  localparam logic [15:0] CMD_SET   = 16'h0005;
  localparam logic [15:0] CMD_QFN   = 16'h0001;
  localparam logic [15:0] CMD_QGRP  = 16'h0003;

  localparam logic [CBV_IDX_W-1:0] IDX_LIST = 2'd0;
  localparam logic [CBV_IDX_W-1:0] IDX_SET  = 2'd1;
  localparam logic [CBV_IDX_W-1:0] IDX_QFN  = 2'd2;
  localparam logic [CBV_IDX_W-1:0] IDX_QGRP = 2'd3;

  localparam logic [15:0] RSP_GOOD    = 16'h0010;
  localparam logic [15:0] RSP_BAD_LEN = 16'h0020;
  localparam logic [15:0] RSP_BAD_CMD = 16'h0030;
  localparam logic [15:0] RSP_SMALL   = 16'h0040;

  localparam logic [CBV_CC_W-1:0] CC_OK    = 2'd0;
  localparam logic [CBV_CC_W-1:0] CC_NOFIT = 2'd3;

  // Range and alignment test on a byte length.
  function automatic logic len_in_bounds(input int len, input int lo,
                                         input int hi, input int align);
    return (len >= lo) && (len <= hi) && ((len % align) == 0);
  endfunction

  // Joint size limit of the request and response areas.
  function automatic logic pair_fits(input int a, input int b, input int limit);
    return (a + b) <= limit;
  endfunction

  // Entries that fit after a header, and whether the body divides evenly.
  function automatic int fit_count(input int len, input int hdr, input int entry);
    return (len - hdr) / entry;
  endfunction

  function automatic logic fit_exact(input int len, input int hdr, input int entry);
    return ((len - hdr) % entry) == 0;
  endfunction

endpackage

// File: rtl/cbv_len_bounds.sv
module cbv_len_bounds #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 8,
  parameter int MAX_LEN = 8176,
  parameter int ALIGN   = 8
) (
  input  logic [LEN_W-1:0] len_i,
  output logic             ok_o
);
  localparam int LEN_INT_W = LEN_W;

  logic [31:0] len_wide;
  assign len_wide = {{(32-LEN_INT_W){1'b0}}, len_i};
  assign ok_o = cbv_pkg::len_in_bounds(int'(len_wide), MIN_LEN, MAX_LEN, ALIGN);
endmodule

// File: rtl/cbv_cmd_map.sv
module cbv_cmd_map #(
  parameter int CODE_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              known_o,
  output logic              is_list_o,
  output logic [IDX_W-1:0]  idx_o
);
  import cbv_pkg::*;

  always_comb begin
    known_o   = 1'b1;
    is_list_o = 1'b0;
    idx_o     = '0;
    unique case (code_i)
      CODE_W'(CMD_LIST): begin idx_o = IDX_W'(IDX_LIST); is_list_o = 1'b1; end
      CODE_W'(CMD_SET):  idx_o = IDX_W'(IDX_SET);
      CODE_W'(CMD_QFN):  idx_o = IDX_W'(IDX_QFN);
      CODE_W'(CMD_QGRP): idx_o = IDX_W'(IDX_QGRP);
      default:           known_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cbv_list_fit.sv
module cbv_list_fit #(
  parameter int LEN_W     = 16,
  parameter int MIN_LEN   = 48,
  parameter int HDR_LEN   = 32,
  parameter int ENTRY_LEN = 32
) (
  input  logic [LEN_W-1:0] rsp_len_i,
  output logic             too_small_o,
  output logic             misfit_o,
  output logic [LEN_W-1:0] entries_o
);
  logic [31:0] len_wide;
  int          count;

  assign len_wide    = {{(32-LEN_W){1'b0}}, rsp_len_i};
  assign too_small_o = int'(len_wide) < MIN_LEN;
  assign misfit_o    = !too_small_o &&
                       !cbv_pkg::fit_exact(int'(len_wide), HDR_LEN, ENTRY_LEN);
  assign count       = cbv_pkg::fit_count(int'(len_wide), HDR_LEN, ENTRY_LEN);
  assign entries_o   = (too_small_o || misfit_o) ? '0 : LEN_W'(count);
endmodule

// File: rtl/cmd_hdr_validator.sv
module cmd_hdr_validator #(
  parameter int LEN_W      = cbv_pkg::CBV_LEN_W,
  parameter int REQ_MIN    = 16,
  parameter int REQ_MAX    = 8184,
  parameter int RSP_MIN    = 8,
  parameter int RSP_MAX    = 8176,
  parameter int LEN_ALIGN  = 8,
  parameter int PAIR_LIMIT = 8192,
  parameter int REQ_EXACT  = 32,
  parameter int LIST_MIN   = 48,
  parameter int LIST_HDR   = 32,
  parameter int LIST_ENTRY = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic                           problem_state_i,
  input  logic [LEN_W-1:0]               req_len_i,
  input  logic [LEN_W-1:0]               rsp_len_i,
  input  logic [LEN_W-1:0]               cmd_code_i,
  output logic                           out_valid_o,
  output logic [cbv_pkg::CBV_OUT_W-1:0]  outcome_o,
  output logic [cbv_pkg::CBV_IDX_W-1:0]  cmd_idx_o,
  output logic [LEN_W-1:0]               rsp_code_o,
  output logic [cbv_pkg::CBV_CC_W-1:0]   cond_code_o,
  output logic [LEN_W-1:0]               list_entries_o
);
  import cbv_pkg::*;

  localparam int OUT_W = CBV_OUT_W;
  localparam int IDX_W = CBV_IDX_W;
  localparam int CC_W  = CBV_CC_W;

  // Named internal events
  logic req_ok, rsp_ok, pair_ok, req_exact;
  logic cmd_known, cmd_is_list;
  logic [IDX_W-1:0] cmd_idx;
  logic list_small, list_misfit;
  logic [LEN_W-1:0] list_count;
  logic ev_priv, ev_oper, ev_lenerr, ev_disp;

  cbv_len_bounds #(.LEN_W(LEN_W), .MIN_LEN(REQ_MIN), .MAX_LEN(REQ_MAX),
                   .ALIGN(LEN_ALIGN)) u_req_bounds (
    .len_i (req_len_i),
    .ok_o  (req_ok)
  );

  cbv_len_bounds #(.LEN_W(LEN_W), .MIN_LEN(RSP_MIN), .MAX_LEN(RSP_MAX),
                   .ALIGN(LEN_ALIGN)) u_rsp_bounds (
    .len_i (rsp_len_i),
    .ok_o  (rsp_ok)
  );

  cbv_cmd_map #(.CODE_W(LEN_W), .IDX_W(IDX_W)) u_cmd_map (
    .code_i    (cmd_code_i),
    .known_o   (cmd_known),
    .is_list_o (cmd_is_list),
    .idx_o     (cmd_idx)
  );

  cbv_list_fit #(.LEN_W(LEN_W), .MIN_LEN(LIST_MIN), .HDR_LEN(LIST_HDR),
                 .ENTRY_LEN(LIST_ENTRY)) u_list_fit (
    .rsp_len_i   (rsp_len_i),
    .too_small_o (list_small),
    .misfit_o    (list_misfit),
    .entries_o   (list_count)
  );

  logic [31:0] req_wide, rsp_wide;
  assign req_wide  = {{(32-LEN_W){1'b0}}, req_len_i};
  assign rsp_wide  = {{(32-LEN_W){1'b0}}, rsp_len_i};
  assign pair_ok   = pair_fits(int'(req_wide), int'(rsp_wide), PAIR_LIMIT);
  assign req_exact = int'(req_wide) == REQ_EXACT;

  // Priority chain: privilege, request, response, joint, exact length, command
  assign ev_priv   = problem_state_i;
  assign ev_oper   = !ev_priv && !(req_ok && rsp_ok && pair_ok);
  assign ev_lenerr = !ev_priv && !ev_oper && !req_exact;
  assign ev_disp   = !ev_priv && !ev_oper && req_exact;

  logic [OUT_W-1:0] nxt_out;
  logic [IDX_W-1:0] nxt_idx;
  logic [LEN_W-1:0] nxt_rsp;
  logic [CC_W-1:0]  nxt_cc;
  logic [LEN_W-1:0] nxt_ent;

  always_comb begin
    nxt_out = OUT_NONE;
    nxt_idx = '0;
    nxt_rsp = '0;
    nxt_cc  = CC_OK;
    nxt_ent = '0;
    if (ev_priv) begin
      nxt_out = OUT_PRIV;
    end else if (ev_oper) begin
      nxt_out = OUT_OPER;
    end else if (ev_lenerr) begin
      nxt_out = OUT_LENERR;
      nxt_rsp = LEN_W'(RSP_BAD_LEN);
    end else begin
      nxt_out = OUT_DISP;
      if (!cmd_known) begin
        nxt_rsp = LEN_W'(RSP_BAD_CMD);
      end else begin
        nxt_idx = cmd_idx;
        if (!cmd_is_list) begin
          nxt_rsp = LEN_W'(RSP_GOOD);
        end else if (list_small) begin
          nxt_rsp = LEN_W'(RSP_SMALL);
        end else if (list_misfit) begin
          nxt_rsp = LEN_W'(RSP_BAD_LEN);
          nxt_cc  = CC_NOFIT;
        end else begin
          nxt_rsp = LEN_W'(RSP_GOOD);
          nxt_ent = list_count;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o    <= 1'b0;
      outcome_o      <= OUT_NONE;
      cmd_idx_o      <= '0;
      rsp_code_o     <= '0;
      cond_code_o    <= '0;
      list_entries_o <= '0;
    end else begin
      out_valid_o <= start_i;
      if (start_i) begin
        outcome_o      <= nxt_out;
        cmd_idx_o      <= nxt_idx;
        rsp_code_o     <= nxt_rsp;
        cond_code_o    <= nxt_cc;
        list_entries_o <= nxt_ent;
      end else begin
        outcome_o      <= OUT_NONE;
        cmd_idx_o      <= '0;
        rsp_code_o     <= '0;
        cond_code_o    <= '0;
        list_entries_o <= '0;
      end
    end
  end
endmodule

// File: rtl/cbv_checker.sv
module cbv_checker #(
  parameter int LEN_W      = 16,
  parameter int PAIR_LIMIT = 8192,
  parameter int REQ_EXACT  = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             problem_state_i,
  input logic [LEN_W-1:0] req_len_i,
  input logic [LEN_W-1:0] rsp_len_i,
  input logic             out_valid_o,
  input logic [3:0]       outcome_o,
  input logic [1:0]       cmd_idx_o,
  input logic [LEN_W-1:0] rsp_code_o,
  input logic [1:0]       cond_code_o,
  input logic [LEN_W-1:0] list_entries_o
);
  import cbv_pkg::*;

  logic [LEN_W:0] pair_sum;
  assign pair_sum = {1'b0, req_len_i} + {1'b0, rsp_len_i};

  p_priv_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && problem_state_i |=> outcome_o == OUT_PRIV);

  p_pair_limit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !problem_state_i && (int'(pair_sum) > PAIR_LIMIT)
    |=> outcome_o == OUT_OPER);

  p_lenerr_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && outcome_o == OUT_LENERR
    |-> rsp_code_o == LEN_W'(RSP_BAD_LEN) && int'($past(req_len_i)) != REQ_EXACT);

  p_dispatch_exact_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && outcome_o == OUT_DISP |-> int'($past(req_len_i)) == REQ_EXACT);

  p_unknown_idx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && rsp_code_o == LEN_W'(RSP_BAD_CMD)
    |-> outcome_o == OUT_DISP && cmd_idx_o == '0 && list_entries_o == '0);

  p_nofit_cc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && cond_code_o == CC_NOFIT
    |-> outcome_o == OUT_DISP && cmd_idx_o == IDX_LIST &&
        rsp_code_o == LEN_W'(RSP_BAD_LEN) && list_entries_o == '0);

  p_entries_list_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && list_entries_o != '0
    |-> outcome_o == OUT_DISP && cmd_idx_o == IDX_LIST && rsp_code_o == LEN_W'(RSP_GOOD));

  p_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> out_valid_o);

  p_strobe_drop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !out_valid_o);

  p_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $countones(outcome_o) == 1);

  p_idle_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> outcome_o == '0 && rsp_code_o == '0 && cond_code_o == '0 &&
                     cmd_idx_o == '0 && list_entries_o == '0);
endmodule

bind cmd_hdr_validator cbv_checker #(
  .LEN_W(LEN_W), .PAIR_LIMIT(PAIR_LIMIT), .REQ_EXACT(REQ_EXACT)
) u_cbv_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .start_i         (start_i),
  .problem_state_i (problem_state_i),
  .req_len_i       (req_len_i),
  .rsp_len_i       (rsp_len_i),
  .out_valid_o     (out_valid_o),
  .outcome_o       (outcome_o),
  .cmd_idx_o       (cmd_idx_o),
  .rsp_code_o      (rsp_code_o),
  .cond_code_o     (cond_code_o),
  .list_entries_o  (list_entries_o)
);

// File: tb/cmd_hdr_validator_tb.sv
module cmd_hdr_validator_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic problem = 1'b0;
  logic [15:0] req_len = '0, rsp_len = '0, cmd = '0;
  logic out_valid;
  logic [3:0] outcome;
  logic [1:0] idx, cc;
  logic [15:0] rsp_code, entries;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cmd_hdr_validator u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .problem_state_i(problem),
    .req_len_i(req_len), .rsp_len_i(rsp_len), .cmd_code_i(cmd),
    .out_valid_o(out_valid), .outcome_o(outcome), .cmd_idx_o(idx),
    .rsp_code_o(rsp_code), .cond_code_o(cc), .list_entries_o(entries)
  );

  // Reference: the requirement rules restated with bit tests.
  task automatic model(input logic pr, input logic [15:0] rq, input logic [15:0] rs,
                       input logic [15:0] cd, output logic [3:0] e_out,
                       output logic [1:0] e_idx, output logic [15:0] e_rsp,
                       output logic [1:0] e_cc, output logic [15:0] e_ent,
                       output string tag);
    e_out = 4'b0000; e_idx = 2'd0; e_rsp = 16'h0; e_cc = 2'd0; e_ent = 16'h0;
    if (pr) begin
      e_out = 4'b0001; tag = "R1";
    end else if (rq < 16 || rq > 8184 || rq[2:0] != 3'b0) begin
      e_out = 4'b0010; tag = "R2";
    end else if (rs < 8 || rs > 8176 || rs[2:0] != 3'b0) begin
      e_out = 4'b0010; tag = "R3";
    end else if ({1'b0, rq} + {1'b0, rs} > 17'd8192) begin
      e_out = 4'b0010; tag = "R4";
    end else if (rq != 16'd32) begin
      e_out = 4'b0100; e_rsp = 16'h0020; tag = "R5";
    end else begin
      e_out = 4'b1000;
      case (cd)
        16'h0005: begin e_idx = 2'd1; e_rsp = 16'h0010; tag = "R6"; end
        16'h0001: begin e_idx = 2'd2; e_rsp = 16'h0010; tag = "R6"; end
        16'h0003: begin e_idx = 2'd3; e_rsp = 16'h0010; tag = "R6"; end
        16'h0002: begin
          if (rs < 48) begin
            e_rsp = 16'h0040; tag = "R8";
          end else if (rs[4:0] != 5'd0) begin
            e_rsp = 16'h0020; e_cc = 2'd3; tag = "R9";
          end else begin
            e_rsp = 16'h0010; e_ent = (rs >> 5) - 16'd1; tag = "R10";
          end
        end
        default: begin e_rsp = 16'h0030; tag = "R7"; end
      endcase
    end
  endtask

  task automatic run_vec(input logic pr, input logic [15:0] rq, input logic [15:0] rs,
                         input logic [15:0] cd);
    logic [3:0] e_out; logic [1:0] e_idx, e_cc; logic [15:0] e_rsp, e_ent; string tag;
    model(pr, rq, rs, cd, e_out, e_idx, e_rsp, e_cc, e_ent, tag);
    problem = pr; req_len = rq; rsp_len = rs; cmd = cd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tests++;
    if (out_valid !== 1'b1 || outcome !== e_out || idx !== e_idx ||
        rsp_code !== e_rsp || cc !== e_cc || entries !== e_ent) begin
      fails++;
      $display("FAIL %s pr=%0b rq=%0d rs=%0d cmd=%h: got v=%0b out=%b idx=%0d rsp=%h cc=%0d ent=%0d exp v=1 out=%b idx=%0d rsp=%h cc=%0d ent=%0d",
               tag, pr, rq, rs, cd, out_valid, outcome, idx, rsp_code, cc, entries,
               e_out, e_idx, e_rsp, e_cc, e_ent);
    end
  endtask

  // R11: one cycle later everything must be back to zero
  task automatic check_idle();
    @(negedge clk);
    tests++;
    if (out_valid !== 1'b0 || outcome !== 4'b0 || rsp_code !== 16'h0 ||
        cc !== 2'd0 || idx !== 2'd0 || entries !== 16'h0) begin
      fails++;
      $display("FAIL R11 idle: got v=%0b out=%b rsp=%h cc=%0d idx=%0d ent=%0d exp all zero",
               out_valid, outcome, rsp_code, cc, idx, entries);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    tests++;
    if (out_valid !== 1'b0 || outcome !== 4'b0 || rsp_code !== 16'h0 ||
        cc !== 2'd0 || idx !== 2'd0 || entries !== 16'h0) begin
      fails++;
      $display("FAIL R12 reset: got v=%0b out=%b rsp=%h exp zero", out_valid, outcome, rsp_code);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1: privilege wins over every other input
    run_vec(1'b1, 16'd32, 16'd64, 16'h0002);
    run_vec(1'b1, 16'd0, 16'd0, 16'hFFFF);
    run_vec(1'b1, 16'd8184, 16'd8176, 16'h0005);
    run_vec(1'b1, 16'd33, 16'd7, 16'h0001);
    check_idle();

    // R2 sweep over the request length, response kept legal
    for (int r = 0; r <= 8200; r += 2) run_vec(1'b0, 16'(r), 16'd8, 16'h0002);
    check_idle();

    // R3, R4, R8, R9, R10 sweep over the response length with a list command
    for (int r = 0; r <= 8200; r += 2) run_vec(1'b0, 16'd32, 16'(r), 16'h0002);
    check_idle();

    // R4 joint limit diagonal: exactly at the limit and one step over
    for (int q = 16; q <= 8184; q += 8) begin
      run_vec(1'b0, 16'(q), 16'(8192 - q), 16'h0003);
      run_vec(1'b0, 16'(q), 16'(8200 - q), 16'h0003);
    end
    // R4 with large lengths
    run_vec(1'b0, 16'd8184, 16'd8176, 16'h0002);

    // R6, R7 command code sweep
    for (int c = 0; c < 64; c++) run_vec(1'b0, 16'd32, 16'd96, 16'(c));
    run_vec(1'b0, 16'd32, 16'd96, 16'hFFFF);
    run_vec(1'b0, 16'd32, 16'd96, 16'h8002);
    check_idle();

    // R5 with an otherwise valid command
    run_vec(1'b0, 16'd40, 16'd64, 16'h0005);
    run_vec(1'b0, 16'd24, 16'd64, 16'h0002);
    check_idle();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule